// File: doc/BRIEF.md
# Infrared Pulse Transmitter with Carrier Modulation

This block plays a queue of pulse descriptors onto an infrared emitter pin. Each descriptor holds a level (mark or space) and a duration counted in ticks of a programmable clock divider. The host pushes descriptors into a small internal FIFO. The block takes them one by one and holds each level for its full duration. Consecutive descriptors follow each other with no gap.

Whether an interval carries the carrier burst depends on its level and on a polarity bit. With modulation on, a burst interval is chopped by a carrier. The carrier period is 16 ticks and its high time is set in sixteenths. With modulation off, a burst interval drives a steady active level. The final pin level can be inverted.

The host sees two status outputs. A busy flag reports that a descriptor is playing or still queued. A FIFO service request has two selectable conditions, and it can be gated onto an interrupt line.

Top module: `irtx_pulse_engine`

## Requirements
- R1: A tick occurs every cfg_div+1 clock cycles, and the divider restarts when a descriptor is taken while idle. A descriptor of duration d therefore holds its level for exactly d*(cfg_div+1) clock cycles.
- R2: A duration field of zero is played as one tick.
- R3: With cfg_mod_en=0, a burst interval drives the raw level high for its whole length. With cfg_mod_en=1, the raw level follows a carrier of 16 ticks per period. The carrier is high during phases 0 to cfg_duty, that is, for cfg_duty+1 ticks.
- R4: wr_level=1 is mark and wr_level=0 is space. With cfg_burst_on_space=0, mark intervals carry the burst. With cfg_burst_on_space=1, space intervals carry it. Intervals without a burst drive raw level 0.
- R5: ir_out equals the raw level XOR cfg_invert. When nothing is playing, the raw level is 0, so ir_out equals cfg_invert.
- R6: The carrier phase restarts at 0 when a burst interval begins after idle or after a non-burst interval. It keeps running across consecutive burst intervals.
- R7: When a descriptor ends and another is queued, the next one starts in the following cycle, with no idle cycle between them.
- R8: busy is high exactly while a descriptor is playing or the FIFO is non-empty.
- R9: svc_req is high when the FIFO is empty-or-at-most-half-full (occupancy <= DEPTH/2) if cfg_req_not_empty=0. It is high when the FIFO is non-empty if cfg_req_not_empty=1. irq equals svc_req AND cfg_irq_en.
- R10: A write is dropped when the FIFO is full or when cfg_fifo_en=0.
- R11: While cfg_tx_en=0, no descriptor is taken from the FIFO, and the output stays at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx_en | input | 1 | Transmitter enable |
| cfg_mod_en | input | 1 | Carrier modulation enable |
| cfg_fifo_en | input | 1 | FIFO write enable |
| cfg_div | input | 16 | Divider; tick period is cfg_div+1 clocks |
| cfg_duty | input | 4 | Carrier high time minus one, in ticks |
| cfg_burst_on_space | input | 1 | 1: burst during space, 0: burst during mark |
| cfg_invert | input | 1 | Invert pin level |
| cfg_req_not_empty | input | 1 | Service-request condition select |
| cfg_irq_en | input | 1 | Service-request interrupt enable |
| wr_valid | input | 1 | Push a descriptor |
| wr_level | input | 1 | Descriptor level, 1 = mark |
| wr_dur | input | 16 | Descriptor duration in ticks |
| wr_full | output | 1 | FIFO full |
| ir_out | output | 1 | Emitter pin |
| busy | output | 1 | Transmitter busy |
| svc_req | output | 1 | FIFO service request |
| irq | output | 1 | Gated service request |

## Verification
Two events can fall in the same cycle: the last tick of one descriptor, and the fetch of the next one together with its carrier-phase decision. The bench queues descriptor chains before it enables the transmitter, so every hand-off happens at such a boundary. Two chains cover the phase decision. In mark, space, mark, the phase must restart. In mark, mark, it must continue. The total number of carrier-high cycles differs by a known amount between restarted and continued phase, and the busy-cycle total shows whether any gap cycle crept in.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  localparam int unsigned DUR_W   = 16;
  localparam int unsigned PHASE_W = 4;   // 16 ticks per carrier period

  typedef struct packed {
    logic             level;  // 1 = mark
    logic [DUR_W-1:0] dur;
  } irtx_desc_t;
endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo
  import irtx_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  irtx_desc_t                   wr_data,
  input  logic                         rd_en,
  output irtx_desc_t                   rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  irtx_desc_t      mem [DEPTH];
  logic [AW-1:0]   wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            do_wr, do_rd;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign count   = cnt_q;
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_wr) wptr_d = (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
    if (do_rd) rptr_d = (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
    case ({do_wr, do_rd})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q] <= wr_data;
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> full);
endmodule

// File: rtl/irtx_tick.sv
module irtx_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    if (!run || restart || tick) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || !$stable(div)));
endmodule

// File: rtl/irtx_seq.sv
module irtx_seq
  import irtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       mod_en,
  input  logic       pol_space,
  input  logic [3:0] duty,
  input  logic       tick,
  input  logic       avail,
  input  irtx_desc_t head,
  output logic       pop,
  output logic       restart,
  output logic       active,
  output logic       raw
);
  logic               act_q, act_d;
  logic               lvl_q, lvl_d;
  logic [DUR_W-1:0]   rem_q, rem_d;
  logic [PHASE_W-1:0] ph_q, ph_d;
  logic               last, burst, head_burst;

  assign last       = act_q && tick && (rem_q == DUR_W'(1));
  assign pop        = tx_en && avail && (!act_q || last);
  assign restart    = pop && !act_q;
  assign burst      = act_q && (lvl_q ^ pol_space);
  assign head_burst = head.level ^ pol_space;

  always_comb begin
    act_d = act_q;
    lvl_d = lvl_q;
    rem_d = rem_q;
    ph_d  = ph_q;
    if (act_q && tick) begin
      rem_d = rem_q - 1'b1;
      ph_d  = ph_q + 1'b1;
    end
    if (last) act_d = 1'b0;
    if (pop) begin
      act_d = 1'b1;
      lvl_d = head.level;
      rem_d = (head.dur == '0) ? DUR_W'(1) : head.dur;
      if (head_burst && !burst) ph_d = '0;
    end
    if (!tx_en) act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      lvl_q <= 1'b0;
      rem_q <= '0;
      ph_q  <= '0;
    end else begin
      act_q <= act_d;
      lvl_q <= lvl_d;
      rem_q <= rem_d;
      ph_q  <= ph_d;
    end
  end

  assign active = act_q;
  assign raw    = burst && (!mod_en || (ph_q <= duty));

  assert_rem_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> rem_q != '0);
  assert_hold_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !act_q);
  assert_phase_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && head_burst && !burst) |=> ph_q == '0);
endmodule

// File: rtl/irtx_pulse_engine.sv
module irtx_pulse_engine
  import irtx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_tx_en,
  input  logic             cfg_mod_en,
  input  logic             cfg_fifo_en,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [3:0]       cfg_duty,
  input  logic             cfg_burst_on_space,
  input  logic             cfg_invert,
  input  logic             cfg_req_not_empty,
  input  logic             cfg_irq_en,
  input  logic             wr_valid,
  input  logic             wr_level,
  input  logic [DUR_W-1:0] wr_dur,
  output logic             wr_full,
  output logic             ir_out,
  output logic             busy,
  output logic             svc_req,
  output logic             irq
);
  localparam int unsigned CW   = $clog2(DEPTH+1);
  localparam int unsigned HALF = DEPTH / 2;

  logic          rst_m_q, rst_s_q;
  logic          tick, pop, restart, active, raw, empty;
  logic [CW-1:0] count;
  irtx_desc_t    wdesc, head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  assign wdesc.level = wr_level;
  assign wdesc.dur   = wr_dur;

  irtx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s_q),
    .wr_en(wr_valid && cfg_fifo_en), .wr_data(wdesc),
    .rd_en(pop), .rd_data(head),
    .count(count), .empty(empty), .full(wr_full)
  );

  irtx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_s_q), .run(cfg_tx_en),
    .restart(restart), .div(cfg_div), .tick(tick)
  );

  irtx_seq u_seq (
    .clk(clk), .rst_n(rst_s_q), .tx_en(cfg_tx_en), .mod_en(cfg_mod_en),
    .pol_space(cfg_burst_on_space), .duty(cfg_duty), .tick(tick),
    .avail(!empty), .head(head), .pop(pop), .restart(restart),
    .active(active), .raw(raw)
  );

  assign ir_out  = raw ^ cfg_invert;
  assign busy    = active || !empty;
  assign svc_req = cfg_req_not_empty ? !empty : (count <= CW'(HALF));
  assign irq     = svc_req && cfg_irq_en;

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_s_q)
    !busy |-> ir_out == cfg_invert);
  assert_queue_busy_R8: assert property (@(posedge clk) disable iff (!rst_s_q)
    !empty |-> busy);
endmodule

// File: tb/sim_irtx_pulse_engine.sv
module sim_irtx_pulse_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic        level;
    logic [15:0] dur;
    logic        pol;
    logic        modu;
    logic [3:0]  duty;
    logic        inv;
    logic [15:0] div;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'd5,  1'b0, 1'b0, 4'd0,  1'b0, 16'd0},
    '{1'b1, 16'd0,  1'b0, 1'b0, 4'd0,  1'b0, 16'd2},
    '{1'b0, 16'd4,  1'b0, 1'b0, 4'd0,  1'b0, 16'd1},
    '{1'b0, 16'd4,  1'b1, 1'b0, 4'd0,  1'b0, 16'd1},
    '{1'b1, 16'd40, 1'b0, 1'b1, 4'd3,  1'b0, 16'd0},
    '{1'b1, 16'd20, 1'b0, 1'b1, 4'd7,  1'b1, 16'd1},
    '{1'b1, 16'd33, 1'b0, 1'b1, 4'd15, 1'b0, 16'd0},
    '{1'b1, 16'd17, 1'b0, 1'b1, 4'd0,  1'b0, 16'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_tx_en = 0, cfg_mod_en = 0, cfg_fifo_en = 1;
  logic [15:0] cfg_div = '0;
  logic [3:0] cfg_duty = '0;
  logic cfg_burst_on_space = 0, cfg_invert = 0, cfg_req_not_empty = 0, cfg_irq_en = 0;
  logic wr_valid = 0, wr_level = 0;
  logic [15:0] wr_dur = '0;
  logic wr_full, ir_out, busy, svc_req, irq;
  int total = 0, bad = 0, cyc = 0;
  int bn, hn;

  always #(CLK_PERIOD/2) clk = ~clk;

  irtx_pulse_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_mod_en(cfg_mod_en),
    .cfg_fifo_en(cfg_fifo_en), .cfg_div(cfg_div), .cfg_duty(cfg_duty),
    .cfg_burst_on_space(cfg_burst_on_space), .cfg_invert(cfg_invert),
    .cfg_req_not_empty(cfg_req_not_empty), .cfg_irq_en(cfg_irq_en),
    .wr_valid(wr_valid), .wr_level(wr_level), .wr_dur(wr_dur),
    .wr_full(wr_full), .ir_out(ir_out), .busy(busy), .svc_req(svc_req), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic lv, input int d);
    @(negedge clk);
    wr_valid = 1'b1; wr_level = lv; wr_dur = 16'(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic measure(output int b, output int h);
    b = 0; h = 0;
    while (busy && b < 5000) begin
      b++;
      if (ir_out != cfg_invert) h++;
      @(negedge clk);
    end
  endtask

  function automatic int exp_high(input vec_t v);
    int n, s;
    n = (v.dur == 0) ? 1 : int'(v.dur);
    s = 0;
    if (!(v.level ^ v.pol)) return 0;
    for (int t = 0; t < n; t++)
      if (!v.modu || (t % 16) <= int'(v.duty)) s += int'(v.div) + 1;
    return s;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    check("R5 reset ir_out", ir_out, 0);
    check("R8 reset busy", busy, 0);
    check("R9 reset svc_req", svc_req, 1);

    // table walk: R1 R2 R3 R4 R5
    cfg_tx_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      @(negedge clk);
      cfg_burst_on_space = v.pol; cfg_mod_en = v.modu; cfg_duty = v.duty;
      cfg_invert = v.inv; cfg_div = v.div;
      push(v.level, int'(v.dur));
      measure(bn, hn);
      check("R1 R2 busy span", bn, 1 + ((v.dur == 0) ? 1 : int'(v.dur)) * (int'(v.div) + 1));
      check("R3 R4 high cycles", hn, exp_high(v));
      check("R5 idle level", ir_out, int'(v.inv));
    end

    // R6 restart after space; R7 seamless chain
    @(negedge clk);
    cfg_tx_en = 0; cfg_invert = 0; cfg_div = 0; cfg_mod_en = 1; cfg_duty = 3;
    cfg_burst_on_space = 0;
    push(1, 20); push(0, 3); push(1, 6);
    @(negedge clk); cfg_tx_en = 1;
    measure(bn, hn);
    check("R6 phase restart highs", hn, 12);
    check("R7 chain busy span", bn, 30);

    // R6 continuation across mark-mark
    @(negedge clk); cfg_tx_en = 0;
    push(1, 6); push(1, 6);
    @(negedge clk); cfg_tx_en = 1;
    measure(bn, hn);
    check("R6 phase continue highs", hn, 4);
    check("R7 mark-mark busy span", bn, 13);

    // R9 service request, R10 overflow drop, R11 hold
    @(negedge clk); cfg_tx_en = 0; cfg_mod_en = 0; cfg_irq_en = 1;
    for (int k = 0; k < 4; k++) push(1, 2);
    check("R9 half-full svc", svc_req, 1);
    check("R9 irq gated", irq, 1);
    push(1, 2);
    check("R9 above half svc", svc_req, 0);
    check("R9 irq follows", irq, 0);
    cfg_req_not_empty = 1;
    @(negedge clk);
    check("R9 not-empty svc", svc_req, 1);
    for (int k = 0; k < 4; k++) push(1, 2);
    check("R10 full flag", wr_full, 1);
    repeat (5) @(negedge clk);
    check("R11 no playout", ir_out, 0);
    check("R8 busy with queue", busy, 1);
    cfg_tx_en = 1;
    measure(bn, hn);
    check("R10 dropped write", hn, 16);
    check("R9 not-empty svc idle", svc_req, 0);

    // R10 FIFO disabled
    @(negedge clk); cfg_tx_en = 0; cfg_fifo_en = 0;
    push(1, 3);
    @(negedge clk);
    check("R10 fifo disabled", busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule